// File: doc/BRIEF.md
# Windowed Watchdog with Early Warning

This block supervises software with a 7-bit down-counter that must be refreshed inside a time slot. Once armed, the counter steps down once per tick period, which is a multiple of the bus clock picked by a 2-bit divider field. If the counter steps from 0x40 to 0x3F, the block raises its reset output. Software refreshes by writing a new counter value. That write is only legal once the counter has fallen to or below a programmed window value. A refresh that arrives while the counter is still above the window is treated as a fault as well. Either fault raises the reset, so software has to keep its refresh period within a band.

An optional early-warning flag is set when the counter steps into 0x40. An interrupt line follows that flag, so a handler can save state or refresh before the reset. A debug-freeze option stops the count while an external halt input is high. When the reset output pulses, the block itself goes back to its power-on state, just as the rest of the system would.

Software talks to the block through a plain write port and a combinational read port. There are three registers. CONTROL at address 0 holds the arm bit and the counter. SETUP at address 1 holds the window, the divider, the warning enable and the freeze enable. FLAGS at address 2 holds the warning flag.

Top module: `winwdog`

## Requirements
- R1: After rst_n low the block reads as follows: CONTROL = 0x07F (disarmed, counter 0x7F); SETUP = 0x07F (window 0x7F, divider 0, warning off, freeze off); FLAGS = 0. Both wdg_rst and irq are low.
- R2: While armed, the counter drops by exactly one every PRE_BASE × 2^div bus clocks. The prescaler restarts at every accepted CONTROL write. While disarmed, the counter holds its value.
- R3: CONTROL layout is bit 7 = arm and bits 6:0 = counter. A CONTROL write with bit 7 = 1 arms the block. A CONTROL write with bit 7 = 0 never disarms it; only wdg_rst or rst_n does.
- R4: When an armed counter steps from 0x40 to 0x3F, wdg_rst is high for the cycle that follows that step. In that same cycle the block reads back its R1 state.
- R5: A CONTROL write made while armed with counter > window loads nothing. It raises wdg_rst in the next cycle, and the block returns to its R1 state.
- R6: A CONTROL write made while disarmed, or while armed with counter ≤ window (equality included), loads bits 6:0 into the counter without a reset.
- R7: An accepted CONTROL write that leaves the block armed with counter bit 6 = 0 raises wdg_rst in the next cycle.
- R8: SETUP layout is bits 6:0 = window, bits 8:7 = divider, bit 9 = warning enable and bit 10 = freeze enable. With warning enable = 1, the FLAGS bit 0 flag sets when the counter steps into 0x40. irq is high while the flag and warning enable are both 1. With warning enable = 0 the flag stays 0.
- R9: A FLAGS write with bit 0 = 0 clears the flag. A FLAGS write with bit 0 = 1 leaves the flag unchanged.
- R10: With freeze enable = 1 and dbg_halt high, the counter and prescaler hold. With freeze enable = 0, dbg_halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 CONTROL, 1 SETUP, 2 FLAGS) |
| wr_data | input | 11 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 11 | Read data, combinational from rd_addr |
| dbg_halt | input | 1 | Debug halt indication |
| wdg_rst | output | 1 | One-cycle watchdog reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
A wrong counter state shows up at the CONTROL read port in the cycle right after the edge that corrupted it. It then shifts the wdg_rst pulse by whole tick periods, and the bench counts those cycles from the arming write. A wrong window compare or bit-6 check appears as a wdg_rst pulse that is present or missing one cycle after the offending write. A wrong warning flag is visible on irq and FLAGS on the same cycle the counter reaches 0x40. That is one tick period ahead of the timeout.

// File: rtl/winwdog_pkg.sv
`timescale 1ns/1ps
package winwdog_pkg;
  localparam int CNT_W = 7;
  localparam int REG_W = 11;
  localparam logic [CNT_W-1:0] CNT_INIT  = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_TRIP  = 7'h40;
  localparam logic [CNT_W-1:0] CNT_WARN0 = 7'h41;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SETUP = 2'd1;
  localparam logic [1:0] ADDR_FLAGS = 2'd2;

  typedef struct packed {
    logic             frz_en;
    logic             warn_en;
    logic [1:0]       div;
    logic [CNT_W-1:0] win;
  } setup_t;

  localparam setup_t SETUP_INIT = '{frz_en: 1'b0, warn_en: 1'b0, div: 2'd0, win: 7'h7F};

  // bus clocks per counter step
  function automatic int unsigned tick_period(int unsigned base, logic [1:0] sel);
    return base << sel;
  endfunction

  // refresh is legal once the counter has fallen into the window
  function automatic logic in_window(logic [CNT_W-1:0] c, logic [CNT_W-1:0] w);
    return c <= w;
  endfunction

  // the next step would clear bit 6
  function automatic logic at_trip(logic [CNT_W-1:0] c);
    return c == CNT_TRIP;
  endfunction
endpackage

// File: rtl/winwdog_prescale.sv
`timescale 1ns/1ps
module winwdog_prescale
  import winwdog_pkg::*;
#(
  parameter int unsigned PRE_BASE = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int unsigned MAXP = PRE_BASE * 8;
  localparam int PW = $clog2(MAXP);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] last;

  assign last = PW'(tick_period(PRE_BASE, div_sel) - 1);
  assign tick = run && (pcnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (run)          pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(pcnt));
endmodule

// File: rtl/winwdog_counter.sv
`timescale 1ns/1ps
module winwdog_counter
  import winwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_ctrl,
  input  logic             wr_arm,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [CNT_W-1:0] win,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             warn_step,
  output logic             load,
  output logic             fault
);
  logic early, bad_load, step, expire, next_arm;

  always_comb begin
    early     = wr_ctrl && armed && !in_window(cnt, win);
    load      = wr_ctrl && !early;
    next_arm  = armed | wr_arm;
    bad_load  = load && next_arm && !wr_cnt[CNT_W-1];
    step      = armed && tick && !wr_ctrl;
    expire    = step && at_trip(cnt);
    warn_step = step && (cnt == CNT_WARN0);
    fault     = early || bad_load || expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fault) begin
      armed <= 1'b0;
      cnt   <= CNT_INIT;
    end else if (load) begin
      armed <= next_arm;
      cnt   <= wr_cnt;
    end else if (step) begin
      cnt   <= CNT_W'(cnt - 7'd1);
    end
  end

  // armed counter is never seen with bit 6 clear
  p_bit6_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cnt[CNT_W-1]);
  p_early_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && armed && (cnt > win)) |=> (!armed && cnt == CNT_INIT));
  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fault) |=> armed);
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_ctrl) |=> $stable(cnt));
endmodule

// File: rtl/winwdog_regs.sv
`timescale 1ns/1ps
module winwdog_regs
  import winwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_setup,
  input  logic             wr_flags,
  input  logic [REG_W-1:0] wr_data,
  input  logic             warn_step,
  output setup_t           setup,
  output logic             warn_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear)  setup <= SETUP_INIT;
    else if (wr_setup)    setup <= setup_t'(wr_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)                warn_flag <= 1'b0;
    else if (warn_step && setup.warn_en) warn_flag <= 1'b1;
    else if (wr_flags && !wr_data[0])   warn_flag <= 1'b0;
  end

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && !wr_data[0] && !warn_step && !clear) |=> !warn_flag);
  p_flag_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_flag && wr_flags && wr_data[0] && !clear) |=> warn_flag);
endmodule

// File: rtl/winwdog.sv
`timescale 1ns/1ps
module winwdog
  import winwdog_pkg::*;
#(
  parameter int unsigned PRE_BASE = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             dbg_halt,
  output logic             wdg_rst,
  output logic             irq
);
  logic             wr_ctrl, wr_setup, wr_flags;
  logic             armed, tick, warn_step, load, fault, frozen, run;
  logic [CNT_W-1:0] cnt;
  setup_t           setup;
  logic             warn_flag;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_setup = wr_en && (wr_addr == ADDR_SETUP);
  assign wr_flags = wr_en && (wr_addr == ADDR_FLAGS);

  assign frozen = setup.frz_en && dbg_halt;
  assign run    = armed && !frozen;

  winwdog_prescale #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(load || fault),
    .div_sel(setup.div), .tick(tick)
  );

  winwdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_ctrl(wr_ctrl),
    .wr_arm(wr_data[CNT_W]), .wr_cnt(wr_data[CNT_W-1:0]), .win(setup.win),
    .armed(armed), .cnt(cnt), .warn_step(warn_step), .load(load), .fault(fault)
  );

  winwdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clear(fault), .wr_setup(wr_setup),
    .wr_flags(wr_flags), .wr_data(wr_data), .warn_step(warn_step),
    .setup(setup), .warn_flag(warn_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wdg_rst <= 1'b0;
    else        wdg_rst <= fault;
  end

  assign irq = warn_flag && setup.warn_en;

  always_comb begin
    case (rd_addr)
      ADDR_CTRL:  rd_data = REG_W'({armed, cnt});
      ADDR_SETUP: rd_data = setup;
      ADDR_FLAGS: rd_data = REG_W'(warn_flag);
      default:    rd_data = '0;
    endcase
  end

  p_rst_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst |-> (!armed && cnt == CNT_INIT && setup == SETUP_INIT));
  p_warn_at_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_flag) |-> (armed && cnt == CNT_TRIP));
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> warn_flag);
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_ctrl) |=> $stable(cnt));
endmodule

// File: tb/winwdog_tb_top.sv
`timescale 1ns/1ps
module winwdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [10:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [10:0] rd_data;
  logic        dbg_halt = 1'b0;
  logic        wdg_rst, irq;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  winwdog #(.PRE_BASE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_halt(dbg_halt), .wdg_rst(wdg_rst), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic do_reset();
    wr_en = 1'b0; dbg_halt = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [10:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input int exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("reg%0d", a), int'(rd_data), exp);
  endtask

  task automatic cycles_to_rst(output int n);
    n = 0;
    while (!wdg_rst && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    rd_chk("R1", 2'd0, 'h07F);
    rd_chk("R1", 2'd1, 'h07F);
    rd_chk("R1", 2'd2, 0);
    chk("R1", "wdg_rst", int'(wdg_rst), 0);
    chk("R1", "irq", int'(irq), 0);
    repeat (20) @(negedge clk);
    rd_chk("R2", 2'd0, 'h07F);  // disarmed holds
  endtask

  task automatic t_rate_and_sticky();
    do_reset();
    wr(2'd1, 11'h0FF);          // divider 1 -> 8 clocks per step
    wr(2'd0, 11'h0FF);
    repeat (23) @(negedge clk);
    rd_chk("R2", 2'd0, 'h0FD);
    @(negedge clk);
    rd_chk("R2", 2'd0, 'h0FC);
    wr(2'd0, 11'h070);          // arm bit 0, inside window 0x7F
    rd_chk("R3", 2'd0, 'h0F0);
    chk("R3", "wdg_rst", int'(wdg_rst), 0);
  endtask

  task automatic t_timeout_warn();
    int n;
    do_reset();
    wr(2'd1, 11'h27F);          // warning enabled
    wr(2'd0, 11'h0C2);
    repeat (8) @(negedge clk);
    rd_chk("R8", 2'd0, 'h0C0);
    rd_chk("R8", 2'd2, 1);
    chk("R8", "irq", int'(irq), 1);
    wr(2'd2, 11'h001);
    rd_chk("R9", 2'd2, 1);
    wr(2'd2, 11'h000);
    rd_chk("R9", 2'd2, 0);
    chk("R9", "irq", int'(irq), 0);
    cycles_to_rst(n);
    chk("R4", "cycles to reset", n, 2);
    rd_chk("R4", 2'd0, 'h07F);
    rd_chk("R4", 2'd1, 'h07F);
    @(negedge clk);
    chk("R4", "pulse width", int'(wdg_rst), 0);
  endtask

  task automatic t_timeout_nowarn();
    int n;
    do_reset();
    wr(2'd0, 11'h0C2);
    repeat (8) @(negedge clk);
    rd_chk("R8", 2'd2, 0);
    chk("R8", "irq off", int'(irq), 0);
    cycles_to_rst(n);
    chk("R4", "cycles to reset", n, 4);
  endtask

  task automatic t_early_refresh();
    do_reset();
    wr(2'd1, 11'h050);
    wr(2'd0, 11'h0FF);
    chk("R6", "arm write no reset", int'(wdg_rst), 0);
    rd_chk("R6", 2'd0, 'h0FF);
    wr(2'd0, 11'h0FF);          // 0x7F above window 0x50
    chk("R5", "wdg_rst", int'(wdg_rst), 1);
    rd_chk("R5", 2'd0, 'h07F);
    rd_chk("R5", 2'd1, 'h07F);
  endtask

  task automatic t_window_refresh();
    do_reset();
    wr(2'd1, 11'h060);
    wr(2'd0, 11'h0E0);
    wr(2'd0, 11'h0E0);          // counter equals window
    chk("R6", "equal accepted", int'(wdg_rst), 0);
    repeat (3) @(negedge clk);
    rd_chk("R2", 2'd0, 'h0E0);
    @(negedge clk);
    rd_chk("R2", 2'd0, 'h0DF);
    wr(2'd0, 11'h0E5);
    chk("R6", "below window", int'(wdg_rst), 0);
    rd_chk("R6", 2'd0, 'h0E5);
  endtask

  task automatic t_bad_load();
    do_reset();
    wr(2'd0, 11'h03F);          // disarmed, bit6 clear: accepted
    chk("R7", "disarmed load", int'(wdg_rst), 0);
    repeat (10) @(negedge clk);
    rd_chk("R7", 2'd0, 'h03F);
    wr(2'd0, 11'h0BF);          // arm with bit6 clear
    chk("R7", "wdg_rst", int'(wdg_rst), 1);
    rd_chk("R7", 2'd0, 'h07F);
  endtask

  task automatic t_freeze();
    do_reset();
    wr(2'd1, 11'h47F);
    wr(2'd0, 11'h0FF);
    dbg_halt = 1'b1;
    repeat (20) @(negedge clk);
    rd_chk("R10", 2'd0, 'h0FF);
    dbg_halt = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk("R10", 2'd0, 'h0FF);
    @(negedge clk);
    rd_chk("R10", 2'd0, 'h0FE);
    do_reset();
    wr(2'd0, 11'h0FF);          // freeze enable off
    dbg_halt = 1'b1;
    repeat (8) @(negedge clk);
    rd_chk("R10", 2'd0, 'h0FD);
    dbg_halt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    t_reset_state();
    t_rate_and_sticky();
    t_timeout_warn();
    t_timeout_nowarn();
    t_early_refresh();
    t_window_refresh();
    t_bad_load();
    t_freeze();
    report();
  end
endmodule